// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 8K bytes. The host side uses a request/ready handshake. The host presents a request with a write flag, an address and write data while ready is high. The controller takes these values and runs one memory cycle. It returns to ready when the cycle is done. A read also delivers its byte on a result bus, marked by a valid pulse that lasts one cycle.

On the memory side the controller drives the address and two chip enables, one active low and one active high. It also drives an active-low write strobe, an active-low output enable and a data bus. The data bus is split into an outgoing value, an incoming value and a drive enable, and the pad ring resolves them. Every timing minimum of the memory is a nanosecond parameter. It is turned into a whole number of clock cycles (rounded up) from the clock period parameter, and each phase of a cycle is held for that number of cycles.

A write has three phases: a one-cycle setup, a strobe phase and a one-cycle hold. A read has three phases: a one-cycle select, an output-enable wait and a one-cycle capture. When a write follows a read, a turnaround gap is inserted first. During the gap the memory has time to release the bus before the controller drives it.

Top module: `asram_ctrl`

## Requirements
- R1: `host_ready` is high exactly when the controller is idle. After a request is accepted, ready stays low for a fixed number of cycles and then returns: 6 cycles for a read, 6 for a write, and 8 for a write whose previous transaction was a read. These counts apply at the default 4 ns clock and default timings.
- R2: While ready is high, the memory is deselected (`mem_cs_lo_n`=1, `mem_cs_hi`=0), `mem_write_n`=1, `mem_outen_n`=1 and `mem_d_drive`=0.
- R3: `mem_write_n` is low only while both chip enables are active, the controller is driving the data bus and `mem_outen_n` is high.
- R4: Each write strobe lasts at least ceil(T_PWE_NS/period) cycles. When the strobe rises, the write data has been driven for at least T_SD_NS, and the address and both enables have been stable and active for at least T_AW_NS.
- R5: `mem_outen_n` is low only while `mem_write_n` is high and the controller is not driving the bus. Read data is sampled no sooner than T_AA_NS after the address and enables became valid, and no sooner than T_DOE_NS after `mem_outen_n` fell.
- R6: A read's byte appears on `host_rdata` with `host_rvalid` high for exactly one cycle. That cycle is the one in which ready returns high.
- R7: `mem_d_drive` is never asserted within T_HZ_NS of `mem_outen_n` rising. The memory and the controller never drive the bus at the same time.
- R8: Address, write data and the write flag are sampled only in the accepting cycle. Changes to them while ready is low have no effect on the memory cycle in progress.
- R9: `mem_a` stays stable for every cycle in which the memory is selected, including the write hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request; accepted when ready is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle, may accept a request |
| host_rdata | output | 8 | Last read result |
| host_rvalid | output | 1 | One-cycle pulse marking new read data |
| mem_a | output | 13 | Memory address |
| mem_cs_lo_n | output | 1 | Active-low chip enable |
| mem_cs_hi | output | 1 | Active-high chip enable |
| mem_write_n | output | 1 | Active-low write strobe |
| mem_outen_n | output | 1 | Active-low memory output enable |
| mem_d_out | output | 8 | Data toward the memory |
| mem_d_in | input | 8 | Data from the resolved bus |
| mem_d_drive | output | 1 | Enables the controller's bus drivers |

## Verification
A wrong phase count in the sequencer changes the number of cycles that ready stays low, and the cycle-by-cycle model catches this at the cycle where ready should have returned. A read wait that is too short shows up as corrupted read data when the valid pulse arrives, because the memory model returns inverted bits until its access times have passed. A missing turnaround shows up as bus contention a few nanoseconds after the first write setup cycle begins. A strobe that is too short or a missing hold cycle is reported at the edge where the strobe rises.

// File: rtl/asram_pkg.sv
`timescale 1ns/100ps
// Package: shared state type and helpers that turn nanosecond minimums
// into cycle counts. Assumes positive integer clock periods in ns.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_SETUP,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } asram_state_e;

    // Rounds ns up to whole cycles; zero stays zero.
    function automatic int ns2cyc(input int ns, input int period);
        if (ns <= 0) return 0;
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/100ps
// Phase timer: loaded with (cycles - 1) when a phase starts, counts down
// to zero and reports done while at zero. Assumes the loaded value fits.
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count the remaining cycles of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/100ps
// Sequencer: walks the read and write phases, loads the phase timer on
// every state change, and remembers whether the last transaction was a
// read so that a following write gets a bus turnaround gap.
// Assumes every phase length is at least one cycle.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int RD_WAIT_C  = 4,
    parameter int WR_PULSE_C = 4,
    parameter int TURN_C     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_write,
    input  logic             tmr_done,
    output asram_state_e     state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture
);
    asram_state_e state_q, nxt;
    logic         rd_last_q;
    int           dur;

    // Choose the next phase.
    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE:       if (host_req)
                               nxt = host_write ? (rd_last_q ? ST_TURN : ST_WR_SETUP)
                                                : ST_RD_SETUP;
            ST_RD_SETUP:   if (tmr_done) nxt = ST_RD_WAIT;
            ST_RD_WAIT:    if (tmr_done) nxt = ST_RD_CAPTURE;
            ST_RD_CAPTURE: if (tmr_done) nxt = ST_IDLE;
            ST_TURN:       if (tmr_done) nxt = ST_WR_SETUP;
            ST_WR_SETUP:   if (tmr_done) nxt = ST_WR_PULSE;
            ST_WR_PULSE:   if (tmr_done) nxt = ST_WR_HOLD;
            ST_WR_HOLD:    if (tmr_done) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // Length of the phase being entered.
    always_comb begin
        case (nxt)
            ST_RD_WAIT:  dur = RD_WAIT_C;
            ST_WR_PULSE: dur = WR_PULSE_C;
            ST_TURN:     dur = TURN_C;
            default:     dur = 1;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Track whether the most recent accepted transaction was a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_last_q <= 1'b0;
        else if (accept) rd_last_q <= !host_write;
    end

    assign tmr_load = (nxt != state_q);
    assign tmr_val  = CNT_W'(dur - 1);
    assign accept   = (state_q == ST_IDLE) && host_req;
    assign capture  = (state_q == ST_RD_CAPTURE) && tmr_done;
    assign state    = state_q;
endmodule

// File: rtl/asram_pins.sv
`timescale 1ns/100ps
// Pin and host datapath: holds the accepted address and data, decodes the
// memory control pins from the phase, and registers read data.
// Assumes pin outputs are decoded from a single state register.
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asram_state_e      state,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_d_in,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_a,
    output logic              mem_cs_lo_n,
    output logic              mem_cs_hi,
    output logic              mem_write_n,
    output logic              mem_outen_n,
    output logic [DATA_W-1:0] mem_d_out,
    output logic              mem_d_drive
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              rvalid_q, sel;

    // Latch the request fields when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    // Register the bus at the end of the capture phase and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_d_in;
        end
    end

    // Decode memory control pins from the phase.
    always_comb begin
        sel         = (state != ST_IDLE) && (state != ST_TURN);
        mem_cs_lo_n = !sel;
        mem_cs_hi   = sel;
        mem_write_n = (state != ST_WR_PULSE);
        mem_outen_n = !((state == ST_RD_WAIT) || (state == ST_RD_CAPTURE));
        mem_d_drive = (state == ST_WR_SETUP) || (state == ST_WR_PULSE) ||
                      (state == ST_WR_HOLD);
    end

    assign host_ready  = (state == ST_IDLE);
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;
    assign mem_a       = addr_q;
    assign mem_d_out   = wdata_q;
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/100ps
// Top: asynchronous SRAM controller. Converts ns timing minimums into
// phase lengths and wires sequencer, phase timer and pin datapath.
// Assumes the bus is resolved outside from mem_d_out/mem_d_drive.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_RC_NS       = 20,
    parameter int T_AA_NS       = 20,
    parameter int T_DOE_NS      = 9,
    parameter int T_WC_NS       = 20,
    parameter int T_AW_NS       = 15,
    parameter int T_PWE_NS      = 15,
    parameter int T_SD_NS       = 10,
    parameter int T_HZ_NS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_a,
    output logic              mem_cs_lo_n,
    output logic              mem_cs_hi,
    output logic              mem_write_n,
    output logic              mem_outen_n,
    output logic [DATA_W-1:0] mem_d_out,
    input  logic [DATA_W-1:0] mem_d_in,
    output logic              mem_d_drive
);
    localparam int RC_C  = ns2cyc(T_RC_NS,  CLK_PERIOD_NS);
    localparam int AA_C  = ns2cyc(T_AA_NS,  CLK_PERIOD_NS);
    localparam int DOE_C = ns2cyc(T_DOE_NS, CLK_PERIOD_NS);
    localparam int WC_C  = ns2cyc(T_WC_NS,  CLK_PERIOD_NS);
    localparam int AW_C  = ns2cyc(T_AW_NS,  CLK_PERIOD_NS);
    localparam int PWE_C = ns2cyc(T_PWE_NS, CLK_PERIOD_NS);
    localparam int SD_C  = ns2cyc(T_SD_NS,  CLK_PERIOD_NS);
    localparam int HZ_C  = ns2cyc(T_HZ_NS,  CLK_PERIOD_NS);
    // Select cycle precedes the wait; capture cycle follows it.
    localparam int RD_WAIT_C  = imax(imax(1, AA_C - 1), imax(DOE_C, RC_C - 2));
    // Setup cycle precedes the strobe; hold cycle follows it.
    localparam int WR_PULSE_C = imax(imax(imax(1, PWE_C), SD_C),
                                     imax(AW_C - 1, WC_C - 2));
    localparam int TURN_C     = imax(1, HZ_C);
    localparam int MAX_C      = imax(imax(RD_WAIT_C, WR_PULSE_C), TURN_C);
    localparam int CNT_W      = $clog2(MAX_C + 1);

    asram_state_e     state;
    logic             tmr_load, tmr_done, accept, capture;
    logic [CNT_W-1:0] tmr_val;

    asram_seq #(
        .CNT_W      (CNT_W),
        .RD_WAIT_C  (RD_WAIT_C),
        .WR_PULSE_C (WR_PULSE_C),
        .TURN_C     (TURN_C)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_write (host_write),
        .tmr_done   (tmr_done),
        .state      (state),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .capture    (capture)
    );

    asram_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    asram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .accept      (accept),
        .capture     (capture),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .mem_d_in    (mem_d_in),
        .host_ready  (host_ready),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .mem_a       (mem_a),
        .mem_cs_lo_n (mem_cs_lo_n),
        .mem_cs_hi   (mem_cs_hi),
        .mem_write_n (mem_write_n),
        .mem_outen_n (mem_outen_n),
        .mem_d_out   (mem_d_out),
        .mem_d_drive (mem_d_drive)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/100ps
// Checker: protocol properties on the controller's ports, bound to the top.
// Assumes synchronous active-low reset puts all pins idle.
module asram_ctrl_chk
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_PWE_NS      = 15,
    parameter int T_HZ_NS       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_a,
    input logic              mem_cs_lo_n,
    input logic              mem_cs_hi,
    input logic              mem_write_n,
    input logic              mem_outen_n,
    input logic              mem_d_drive
);
    localparam int PULSE_MIN = ns2cyc(T_PWE_NS, CLK_PERIOD_NS);
    localparam int GAP_MIN   = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);

    logic [7:0] gap_q, wlen_q;

    // Cycles since the output enable was last low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_q <= 8'hFF;
        else if (!mem_outen_n)   gap_q <= '0;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
    end

    // Length of the current write strobe (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)              wlen_q <= '0;
        else if (mem_write_n)    wlen_q <= '0;
        else if (wlen_q != 8'hFF) wlen_q <= wlen_q + 1'b1;
    end

    a_r2_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_lo_n && !mem_cs_hi && mem_write_n &&
                        mem_outen_n && !mem_d_drive));

    a_r3_strobe_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_write_n |-> (!mem_cs_lo_n && mem_cs_hi && mem_d_drive && mem_outen_n));

    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_write_n) |-> (int'(wlen_q) >= PULSE_MIN));

    a_r5_outen_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_outen_n |-> (mem_write_n && !mem_d_drive));

    a_r6_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    a_r6_rvalid_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_ready);

    a_r7_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_drive |-> (int'(gap_q) >= GAP_MIN));

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mem_cs_lo_n) && !mem_cs_lo_n) |-> $stable(mem_a));
endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_PWE_NS      (T_PWE_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_a       (mem_a),
    .mem_cs_lo_n (mem_cs_lo_n),
    .mem_cs_hi   (mem_cs_hi),
    .mem_write_n (mem_write_n),
    .mem_outen_n (mem_outen_n),
    .mem_d_drive (mem_d_drive)
);

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/100ps
// Bench: cycle model of the host handshake plus a timed behavioural memory.
module asram_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_write = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic [12:0] mem_a;
    logic        mem_cs_lo_n, mem_cs_hi, mem_write_n, mem_outen_n, mem_d_drive;
    logic [7:0]  mem_d_out;
    logic [7:0]  mem_d_in;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_a(mem_a),
        .mem_cs_lo_n(mem_cs_lo_n), .mem_cs_hi(mem_cs_hi), .mem_write_n(mem_write_n),
        .mem_outen_n(mem_outen_n), .mem_d_out(mem_d_out), .mem_d_in(mem_d_in),
        .mem_d_drive(mem_d_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mm [int];
    logic [7:0] mem_val = 8'h00;
    bit         mem_drv = 1'b0;
    realtime    t_addr = -1000.0, t_sel = -1000.0, t_oef = -1000.0;
    realtime    t_stop = -1000.0, t_wst = -1000.0, t_data = -1000.0;
    bit         wr_seen = 1'b0;
    wire sel_w = (mem_cs_lo_n === 1'b0) && (mem_cs_hi === 1'b1);
    wire rdc_w = sel_w && (mem_outen_n === 1'b0) && (mem_write_n === 1'b1);
    wire wr_w  = sel_w && (mem_write_n === 1'b0);

    assign mem_d_in = mem_drv ? mem_val : 8'h00;

    always @(mem_a) begin
        t_addr = $realtime;
        if (wr_w) chk(1'b0, "R9", "address moved during write", int'(mem_a), 0);
    end
    always @(posedge sel_w) t_sel = $realtime;
    always @(negedge mem_outen_n) t_oef = $realtime;
    always @(negedge rdc_w) t_stop = $realtime;
    always @(mem_d_out or mem_d_drive) t_data = $realtime;
    always @(posedge wr_w) begin t_wst = $realtime; wr_seen = 1'b1; end
    always @(negedge wr_w) if (wr_seen) begin
        wr_seen = 1'b0;
        chk($realtime - t_wst >= 15.0, "R4", "strobe width x10ns",
            int'(($realtime - t_wst) * 10), 150);
        chk(mem_d_drive && ($realtime - t_data >= 10.0), "R4", "data setup x10ns",
            int'(($realtime - t_data) * 10), 100);
        chk($realtime - t_addr >= 15.0 && $realtime - t_sel >= 15.0, "R4",
            "address/enable setup x10ns", int'(($realtime - t_addr) * 10), 150);
        mm[int'(mem_a)] = mem_d_out;
    end

    // Memory output evaluated between clock edges.
    initial begin
        #0.5;
        forever begin
            if (rdc_w) begin
                mem_drv = 1'b1;
                if (($realtime - t_addr >= 20.0) && ($realtime - t_sel >= 20.0) &&
                    ($realtime - t_oef >= 9.0))
                    mem_val = mm[int'(mem_a)];
                else
                    mem_val = ~mm[int'(mem_a)];
            end else begin
                mem_drv = ($realtime - t_stop < 8.0);
            end
            if (mem_d_drive === 1'b1)
                chk(!mem_drv, "R7", "bus contention", int'(mem_drv), 0);
            #1;
        end
    end

    // ---------------- cycle reference model ----------------
    int   busy = 0;
    bit   last_rd = 1'b0, pend_rd = 1'b0, exp_rv = 1'b0;
    logic [7:0] exp_rd = '0;
    logic [7:0] sb [int];
    localparam int P = 4;
    function automatic int cyc(input int ns); return (ns + P - 1) / P; endfunction
    function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
    int rd_len, wr_len, tr_len;

    // One clock: update model at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        exp_rv = 1'b0;
        if (busy == 0 && host_req) begin
            if (host_write) begin
                busy = wr_len + (last_rd ? tr_len : 0);
                sb[int'(host_addr)] = host_wdata;
                last_rd = 1'b0;
            end else begin
                busy = rd_len;
                exp_rd = sb[int'(host_addr)];
                pend_rd = 1'b1;
                last_rd = 1'b1;
            end
        end else if (busy > 0) begin
            busy--;
            if (busy == 0 && pend_rd) begin exp_rv = 1'b1; pend_rd = 1'b0; end
        end
        @(negedge clk);
        chk(host_ready == (busy == 0), "R1", "ready", int'(host_ready), int'(busy == 0));
        chk(host_rvalid == exp_rv, "R6", "rvalid", int'(host_rvalid), int'(exp_rv));
        if (exp_rv)
            chk(host_rdata == exp_rd, "R5", "read data", int'(host_rdata), int'(exp_rd));
        if (busy == 0)
            chk(mem_cs_lo_n && !mem_cs_hi && mem_write_n && mem_outen_n && !mem_d_drive,
                "R2", "idle pins", int'({mem_cs_lo_n, mem_cs_hi, mem_write_n,
                mem_outen_n, mem_d_drive}), 5'b10110);
    endtask

    // Issue one request; scramble the host fields afterwards (R8).
    task automatic op(input bit w, input logic [12:0] a, input logic [7:0] d);
        while (busy != 0) tick();
        host_req = 1'b1; host_write = w; host_addr = a; host_wdata = d;
        tick();
        host_req = 1'b0; host_write = ~w; host_addr = ~a; host_wdata = ~d;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        rd_len = 2 + mx(mx(1, cyc(20) - 1), mx(cyc(9), cyc(20) - 2));
        wr_len = 2 + mx(mx(cyc(15), cyc(10)), mx(cyc(15) - 1, cyc(20) - 2));
        tr_len = mx(1, cyc(8));
        repeat (3) @(negedge clk);
        // R2 reset state
        chk(host_ready && mem_cs_lo_n && !mem_cs_hi && mem_write_n && mem_outen_n &&
            !mem_d_drive && !host_rvalid, "R2", "reset state", int'(host_ready), 1);
        rst_n = 1'b1;
        tick();
        // R1 R4 R8: writes at both address ends and mid-range
        op(1'b1, 13'h0000, 8'h3C);
        op(1'b1, 13'h1FFF, 8'hC3);
        op(1'b1, 13'h0ABC, 8'h5A);
        // R5 R6: back-to-back reads
        op(1'b0, 13'h0000, 8'h00);
        op(1'b0, 13'h1FFF, 8'h00);
        // R7: write right after read needs the turnaround gap
        op(1'b1, 13'h0001, 8'hFF);
        op(1'b0, 13'h0001, 8'h00);
        op(1'b0, 13'h0ABC, 8'h00);
        // overwrite then read back, with idle cycles between
        op(1'b1, 13'h0000, 8'h00);
        repeat (3) tick();
        op(1'b0, 13'h0000, 8'h00);
        // R8 R9: alternating pattern sweep
        for (int i = 0; i < 16; i++) begin
            op(1'b1, 13'(i * 517), 8'(i * 37 + 1));
            if (i % 3 == 0) op(1'b0, 13'(i * 517), 8'h00);
        end
        for (int i = 0; i < 16; i++) op(1'b0, 13'(i * 517), 8'h00);
        while (busy != 0) tick();
        repeat (4) tick();
        finish_run();
    end
endmodule